// File: doc/BRIEF.md
# Left-Justified Stereo Audio Transmitter

This block sends 16-bit signed stereo samples to an external codec over a three-wire serial link: bit clock, word select and serial data. It also drives a master clock for the codec. All clocks come from the system clock through integer dividers. The master clock is a fixed integer fraction of the system clock, set by a parameter. The bit clock is 32 times the sample rate. The master clock is either 256 or 384 times the sample rate.

Framing is left-justified. Word select is low while the left word is sent and high while the right word is sent. The most significant bit of each word goes out in the first bit-clock period after the word-select transition, with no extra bit of delay.

Samples come in as left/right pairs through a ready/valid exchange. The block asks for one pair per frame with a one-cycle `pair_ready_o` pulse at the frame boundary. If no pair is offered at that moment, the block sends a silent frame and raises a sticky underrun flag.

The enable, direction and ratio inputs are copied into the working configuration only on a commit pulse. A commit that carries an unknown ratio code is refused as a whole.

Each output divides down from the system clock as follows:

| Output | Period in system clocks, 256 mode | Period in system clocks, 384 mode |
|---|---|---|
| Master clock | 2 × MCLK_HALF | 2 × MCLK_HALF |
| Bit clock | 16 × MCLK_HALF | 24 × MCLK_HALF |
| Frame (32 bit clocks) | 512 × MCLK_HALF | 768 × MCLK_HALF |

Choosing MCLK_HALF and the system clock so that each listed sample rate (8000, 11025, 22050, 32000, 44100 or 48000 Hz) comes out exactly is the integrator's job.

Top module: `lj_audio_tx`

## Requirements
- R1: `enable_i`, `dir_tx_i` and `ratio_sel_i` have no effect until `commit_i` is high at a rising clock edge. Before the first commit all serial outputs stay low.
- R2: A frame lasts 32 bit-clock periods. `ws_o` is 0 for the 16 left bits and 1 for the 16 right bits, and it changes only when the bit clock falls.
- R3: Each word is sent most significant bit first. Its MSB is valid at the first bit-clock rise after the word-select change. `sd_o` changes only on a bit-clock fall.
- R4: With ratio code 0 (256 mode) the bit-clock period is 16·MCLK_HALF system clocks and holds 8 master-clock periods. The master-clock period is 2·MCLK_HALF system clocks.
- R5: With ratio code 1 (384 mode) the bit-clock period is 24·MCLK_HALF system clocks and holds 12 master-clock periods.
- R6: A commit with ratio code 2 or 3 leaves the working configuration unchanged. It sets `cfg_err_o`, which stays high until the next accepted commit.
- R7: `pair_ready_o` pulses for exactly one cycle per frame, at the frame boundary. In that cycle, if `pair_valid_i` is high, `left_i`/`right_i` are taken as the next frame's data.
- R8: If `pair_valid_i` is low during the `pair_ready_o` pulse, the next frame carries all zeros and `underrun_o` is set. `underrun_o` stays set until `underrun_clr_i` is high at a clock edge with no new underrun.
- R9: While the committed configuration is disabled or set to receive (`dir_tx_i` = 0), `mclk_o`, `bclk_o`, `ws_o` and `sd_o` are held low and no pair is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| commit_i | input | 1 | Copies the setting inputs into the working configuration |
| enable_i | input | 1 | Enable setting |
| dir_tx_i | input | 1 | Direction setting, 1 = transmit, 0 = receive |
| ratio_sel_i | input | 2 | Ratio code: 0 = 256 fs, 1 = 384 fs, 2 and 3 are invalid |
| pair_valid_i | input | 1 | A sample pair is offered |
| left_i | input | 16 | Left sample, two's complement |
| right_i | input | 16 | Right sample, two's complement |
| pair_ready_o | output | 1 | Frame-boundary request; pair taken when valid |
| underrun_clr_i | input | 1 | Clears the underrun flag |
| underrun_o | output | 1 | Sticky underrun flag |
| cfg_err_o | output | 1 | Last commit was refused |
| mclk_o | output | 1 | Codec master clock |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select, 0 = left, 1 = right |
| sd_o | output | 1 | Serial data |

## Verification
The serial stream is decoded at every bit-clock rise and compared with the pair recorded at each request pulse.

Sample pairs are a walking pattern that starts at 0x8000 and 0x7FFF. Their bit order therefore separates MSB-first from LSB-first shifting and left from right placement, and it would expose a one-bit delay.

Both ratio modes are run. Bit-clock period and master-clock counts are measured in each, which separates the 8 and 12 dividers.

Further runs cover:
- withheld data, which must produce a zero frame and a sticky flag;
- a refused ratio code, which must leave the running timing unchanged;
- settings changed without a commit, which must have no effect;
- the receive direction, which must keep every line quiet.

// File: rtl/lj_audio_tx_pkg.sv
package lj_audio_tx_pkg;
  localparam logic [1:0] RATIO_CODE_256 = 2'd0;
  localparam logic [1:0] RATIO_CODE_384 = 2'd1;
  localparam int unsigned RATIO_LO = 256;
  localparam int unsigned RATIO_HI = 384;

  typedef struct packed {
    logic en;
    logic dir_tx;
    logic r384;
  } tx_cfg_t;
endpackage

// File: rtl/lj_cfg_latch.sv
module lj_cfg_latch
  import lj_audio_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       commit_i,
  input  logic       enable_i,
  input  logic       dir_tx_i,
  input  logic [1:0] ratio_sel_i,
  output tx_cfg_t    cfg_o,
  output logic       apply_o,
  output logic       err_o
);
  tx_cfg_t cfg_q;
  logic    apply_q, err_q;
  logic    code_ok;

  assign code_ok = (ratio_sel_i == RATIO_CODE_256) || (ratio_sel_i == RATIO_CODE_384);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      apply_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      apply_q <= 1'b0;
      if (commit_i) begin
        if (code_ok) begin
          cfg_q.en     <= enable_i;
          cfg_q.dir_tx <= dir_tx_i;
          cfg_q.r384   <= (ratio_sel_i == RATIO_CODE_384);
          apply_q      <= 1'b1;
          err_q        <= 1'b0;
        end else begin
          err_q <= 1'b1;
        end
      end
    end
  end

  assign cfg_o   = cfg_q;
  assign apply_o = apply_q;
  assign err_o   = err_q;

  assert_hold_without_commit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(cfg_q));

  assert_bad_code_refused_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !code_ok) |=> (err_q && $stable(cfg_q)));
endmodule

// File: rtl/lj_clk_div.sv
module lj_clk_div
  import lj_audio_tx_pkg::*;
#(
  parameter int unsigned MCLK_HALF  = 1,
  parameter int unsigned FRAME_BITS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic r384_i,
  output logic mclk_o,
  output logic bclk_o,
  output logic bclk_fall_o
);
  // master-clock toggles per bit-clock half period
  localparam int unsigned EDGES_LO = RATIO_LO / FRAME_BITS;
  localparam int unsigned EDGES_HI = RATIO_HI / FRAME_BITS;
  localparam int unsigned EDGE_W   = $clog2(EDGES_HI);
  localparam int unsigned HC_W     = (MCLK_HALF > 1) ? $clog2(MCLK_HALF) : 1;

  logic              mclk_tick, bclk_tick;
  logic              mclk_q, bclk_q;
  logic [EDGE_W-1:0] edge_cnt_q, edge_last;

  generate
    if (MCLK_HALF == 1) begin : g_div1
      assign mclk_tick = run_i;
    end else begin : g_divn
      logic [HC_W-1:0] mc_cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mc_cnt_q <= '0;
        else if (!run_i || mclk_tick) mc_cnt_q <= '0;
        else mc_cnt_q <= mc_cnt_q + 1'b1;
      end
      assign mclk_tick = run_i && (mc_cnt_q == HC_W'(MCLK_HALF - 1));
    end
  endgenerate

  assign edge_last   = r384_i ? EDGE_W'(EDGES_HI - 1) : EDGE_W'(EDGES_LO - 1);
  assign bclk_tick   = mclk_tick && (edge_cnt_q == edge_last);
  assign bclk_fall_o = bclk_tick && bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mclk_q     <= 1'b0;
      bclk_q     <= 1'b0;
      edge_cnt_q <= '0;
    end else if (!run_i) begin
      mclk_q     <= 1'b0;
      bclk_q     <= 1'b0;
      edge_cnt_q <= '0;
    end else if (mclk_tick) begin
      mclk_q     <= ~mclk_q;
      edge_cnt_q <= (edge_cnt_q == edge_last) ? '0 : edge_cnt_q + 1'b1;
      if (bclk_tick) bclk_q <= ~bclk_q;
    end
  end

  assign mclk_o = mclk_q;
  assign bclk_o = bclk_q;

  assert_bclk_with_mclk_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !$stable(bclk_q)) |-> !$stable(mclk_q));
endmodule

// File: rtl/lj_tx_frame.sv
module lj_tx_frame #(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                active_i,
  input  logic                restart_i,
  input  logic                bclk_fall_i,
  input  logic                pair_valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                underrun_clr_i,
  output logic                running_o,
  output logic                pair_ready_o,
  output logic                ws_o,
  output logic                sd_o,
  output logic                underrun_o
);
  localparam int unsigned FRAME_BITS = 2 * SAMPLE_W;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);

  logic                  running_q, underrun_q;
  logic [IDX_W-1:0]      idx_q;
  logic [FRAME_BITS-1:0] shreg_q;
  logic                  boundary;

  assign boundary     = running_q ? (bclk_fall_i && (idx_q == IDX_W'(FRAME_BITS - 1))) : 1'b1;
  assign pair_ready_o = active_i && !restart_i && boundary;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      idx_q     <= '0;
      shreg_q   <= '0;
    end else if (!active_i || restart_i) begin
      running_q <= 1'b0;
      idx_q     <= '0;
      shreg_q   <= '0;
    end else if (pair_ready_o) begin
      running_q <= 1'b1;
      idx_q     <= '0;
      shreg_q   <= pair_valid_i ? {left_i, right_i} : '0;
    end else if (running_q && bclk_fall_i) begin
      idx_q   <= idx_q + 1'b1;
      shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) underrun_q <= 1'b0;
    else if (pair_ready_o && !pair_valid_i) underrun_q <= 1'b1;
    else if (underrun_clr_i) underrun_q <= 1'b0;
  end

  assign running_o  = running_q;
  assign ws_o       = running_q && (idx_q >= IDX_W'(SAMPLE_W));
  assign sd_o       = running_q && shreg_q[FRAME_BITS-1];
  assign underrun_o = underrun_q;

  assert_single_request_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_ready_o |=> !pair_ready_o);

  assert_left_after_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_ready_o |=> !ws_o);

  assert_idle_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (!sd_o && !ws_o && !pair_ready_o));

  assert_underrun_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_q && !underrun_clr_i) |=> underrun_q);

  assert_data_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_q && $past(running_q) && !$stable(sd_o)) |-> $past(bclk_fall_i));
endmodule

// File: rtl/lj_audio_tx.sv
module lj_audio_tx
  import lj_audio_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_W  = 16,
  parameter int unsigned MCLK_HALF = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                commit_i,
  input  logic                enable_i,
  input  logic                dir_tx_i,
  input  logic [1:0]          ratio_sel_i,
  input  logic                pair_valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                pair_ready_o,
  input  logic                underrun_clr_i,
  output logic                underrun_o,
  output logic                cfg_err_o,
  output logic                mclk_o,
  output logic                bclk_o,
  output logic                ws_o,
  output logic                sd_o
);
  localparam int unsigned FRAME_BITS = 2 * SAMPLE_W;

  tx_cfg_t cfg;
  logic    apply, active, running, bclk_fall;

  lj_cfg_latch i_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .commit_i    (commit_i),
    .enable_i    (enable_i),
    .dir_tx_i    (dir_tx_i),
    .ratio_sel_i (ratio_sel_i),
    .cfg_o       (cfg),
    .apply_o     (apply),
    .err_o       (cfg_err_o)
  );

  assign active = cfg.en && cfg.dir_tx;

  lj_clk_div #(
    .MCLK_HALF  (MCLK_HALF),
    .FRAME_BITS (FRAME_BITS)
  ) i_clk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (running),
    .r384_i      (cfg.r384),
    .mclk_o      (mclk_o),
    .bclk_o      (bclk_o),
    .bclk_fall_o (bclk_fall)
  );

  lj_tx_frame #(
    .SAMPLE_W (SAMPLE_W)
  ) i_frame (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .active_i       (active),
    .restart_i      (apply),
    .bclk_fall_i    (bclk_fall),
    .pair_valid_i   (pair_valid_i),
    .left_i         (left_i),
    .right_i        (right_i),
    .underrun_clr_i (underrun_clr_i),
    .running_o      (running),
    .pair_ready_o   (pair_ready_o),
    .ws_o           (ws_o),
    .sd_o           (sd_o),
    .underrun_o     (underrun_o)
  );
endmodule

// File: tb/test_lj_audio_tx.sv
module test_lj_audio_tx;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        commit = 1'b0, enable = 1'b0, dir_tx = 1'b0;
  logic [1:0]  ratio = 2'd0;
  logic        valid = 1'b0, uclr = 1'b0;
  logic [15:0] left = '0, right = '0;
  logic        ready, underrun, cfg_err, mclk, bclk, ws, sd;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lj_audio_tx i_lj_audio_tx (
    .clk_i(clk), .rst_ni(rst_n), .commit_i(commit), .enable_i(enable),
    .dir_tx_i(dir_tx), .ratio_sel_i(ratio), .pair_valid_i(valid),
    .left_i(left), .right_i(right), .pair_ready_o(ready),
    .underrun_clr_i(uclr), .underrun_o(underrun), .cfg_err_o(cfg_err),
    .mclk_o(mclk), .bclk_o(bclk), .ws_o(ws), .sd_o(sd)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int k);
    pat = {16'h8000 ^ 16'(k * 16'h3A51), 16'h7FFF ^ 16'(k * 16'h1C2B)};
  endfunction

  // producer: records what each request takes
  logic [31:0] exp_pair [0:63];
  int n_req = 0;
  bit mon_en = 1'b0;

  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && ready) begin
        exp_pair[n_req % 64] = valid ? {left, right} : 32'h0;
        n_req++;
        @(posedge clk); #1;
        {left, right} = pat(n_req);
      end
    end
  end

  // monitor: decodes the serial stream at bit-clock rises
  int rise_cnt = 0, frames_done = 0, cyc = 0, mrise = 0, rdy_cnt = 0;
  int exp_per = 16, exp_mc = 8;
  bit per_bad = 0, mc_bad = 0, ws_bad = 0;
  logic prev_bclk = 0, prev_mclk = 0;
  logic [31:0] rx = '0;

  always @(negedge clk) begin
    if (mon_en) begin
      int k, f;
      if (ready) rdy_cnt++;
      if (mclk && !prev_mclk) mrise++;
      cyc++;
      if (bclk && !prev_bclk) begin
        k = rise_cnt % 32;
        f = rise_cnt / 32;
        if (rise_cnt > 0) begin
          if (cyc != exp_per) per_bad = 1;
          if (mrise != exp_mc) mc_bad = 1;
        end
        cyc = 0;
        mrise = 0;
        rx[31-k] = sd;
        if (ws != (k >= 16)) ws_bad = 1;
        if (k == 31) begin
          chk(rx == exp_pair[f % 64], "R3 frame data MSB-first", rx, exp_pair[f % 64]);
          chk(!ws_bad, "R2 word select pattern", 32'(ws_bad), 0);
          if (exp_mc == 8)
            chk(!per_bad && !mc_bad, "R4 256-mode clock ratios", {per_bad, mc_bad}, 0);
          else
            chk(!per_bad && !mc_bad, "R5 384-mode clock ratios", {per_bad, mc_bad}, 0);
          chk(rdy_cnt == 1, "R7 one request per frame", 32'(rdy_cnt), 1);
          per_bad = 0; mc_bad = 0; ws_bad = 0; rdy_cnt = 0;
          frames_done++;
        end
        rise_cnt++;
      end
    end
    prev_bclk = bclk;
    prev_mclk = mclk;
  end

  task automatic mon_reset();
    mon_en = 0;
    rise_cnt = 0; frames_done = 0; cyc = 0; mrise = 0; rdy_cnt = 0;
    per_bad = 0; mc_bad = 0; ws_bad = 0; n_req = 0;
    {left, right} = pat(0);
    mon_en = 1;
  endtask

  task automatic do_commit(input logic en, input logic dir, input logic [1:0] code);
    @(posedge clk); #1;
    enable = en; dir_tx = dir; ratio = code; commit = 1;
    @(posedge clk); #1;
    commit = 0;
  endtask

  task automatic wait_frames(input int add, input string req);
    int target = frames_done + add;
    int guard = 0;
    while (frames_done < target && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(frames_done >= target, req, 32'(frames_done), 32'(target));
  endtask

  task automatic idle_window(input int cycles, input string req);
    bit act = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (bclk || mclk || ws || sd || ready) act = 1;
    end
    chk(!act, req, 32'(act), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk({ready, underrun, cfg_err, mclk, bclk, ws, sd} == 7'b0, "R9 reset state",
        32'({ready, underrun, cfg_err, mclk, bclk, ws, sd}), 0);

    // R1: settings without a commit do nothing
    enable = 1; dir_tx = 1; ratio = 2'd0;
    idle_window(300, "R1 no commit, no activity");

    // 256 mode
    valid = 1;
    exp_per = 16; exp_mc = 8;
    mon_reset();
    do_commit(1, 1, 2'd0);
    wait_frames(3, "R4 frames in 256 mode");

    // R1: dropping enable without a commit keeps running
    enable = 0;
    wait_frames(2, "R1 enable change ignored until commit");

    // R6: refused ratio code, timing unchanged
    do_commit(1, 1, 2'd2);
    @(negedge clk);
    chk(cfg_err == 1'b1, "R6 error flag on bad code", 32'(cfg_err), 1);
    wait_frames(2, "R6 running config kept");
    chk(cfg_err == 1'b1, "R6 error flag held", 32'(cfg_err), 1);

    // stop, then R9 idle
    mon_en = 0;
    do_commit(0, 1, 2'd0);
    @(negedge clk);
    chk(cfg_err == 1'b0, "R6 error cleared by good commit", 32'(cfg_err), 0);
    repeat (3) @(negedge clk);
    idle_window(300, "R9 disabled holds lines low");

    // 384 mode
    exp_per = 24; exp_mc = 12;
    mon_reset();
    do_commit(1, 1, 2'd1);
    wait_frames(3, "R5 frames in 384 mode");

    // R8 underrun
    @(posedge clk); #1 valid = 0;
    wait_frames(2, "R8 zero frames on underrun");
    @(negedge clk);
    chk(underrun == 1'b1, "R8 underrun set", 32'(underrun), 1);
    @(posedge clk); #1 valid = 1;
    wait_frames(2, "R8 recovery frames");
    chk(underrun == 1'b1, "R8 underrun sticky", 32'(underrun), 1);
    @(posedge clk); #1 uclr = 1;
    @(posedge clk); #1 uclr = 0;
    @(negedge clk);
    chk(underrun == 1'b0, "R8 underrun cleared", 32'(underrun), 0);

    // R9 receive direction
    mon_en = 0;
    do_commit(1, 0, 2'd0);
    repeat (3) @(negedge clk);
    idle_window(400, "R9 receive direction quiet");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule